// File: doc/BRIEF.md
# Per-Branch History Direction Predictor

This block predicts whether a conditional branch will be taken. It uses two levels of state. Low bits of the branch address pick one shift register from a table of per-branch outcome histories. The value of that history then picks one 2-bit saturating counter from a shared counter table. The counter's upper bit is the prediction. Each branch has its own history, so a pattern that repeats within one branch, such as a short loop that exits every few iterations, lands on a different counter at each position. The predictor can then learn the exit iteration as well as the iterations that continue.

The fetch side presents a branch address on the lookup port. It gets back a taken or not-taken answer in the same cycle, read from the current state. When the branch resolves, the back end presents the branch address and its real outcome on the training port. On that clock edge the counter selected by the branch's history before the edge moves one step toward the outcome. The outcome is also shifted into that branch's history. After reset every history is zero and every counter is weakly not taken.

Top module: `local_hist_predictor`

## Requirements
- R1: After reset every history register holds zero and every counter holds 2'b01 (weakly not taken), so every lookup predicts not taken until training occurs.
- R2: A lookup uses only address bits `[PC_LO +: log2(HIST_ENTRIES)]` to pick a history register; bits below and above that field have no effect. The prediction is the upper bit of the counter indexed by that history.
- R3: A training event moves the selected counter up by one on taken (upd_taken = 1) and down by one on not taken (upd_taken = 0). Counter values 2'b10 and 2'b11 predict taken. The counter stays at 2'b11 on a further taken outcome and stays at 2'b00 on a further not-taken outcome.
- R4: A training event updates the counter indexed by the branch's history as it was before that event. The same event then shifts the outcome into the least significant bit of that history register and discards the oldest bit.
- R5: When upd_valid is low, no history register and no counter changes, whatever upd_pc and upd_taken hold.
- R6: A lookup made in the same cycle as a training event for the same branch returns the prediction from the state before that event. The effect of the training event is visible from the next cycle on.
- R7: All branches share one counter table. Two branches whose histories hold the same value read and train the same counter.
- R8: For a branch that repeats taken, taken, taken, not taken, the predictor makes no misprediction once the history covers the period and each of its counters has been trained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | PC_W | Branch address to predict |
| pred_taken | output | 1 | Prediction for pred_pc (1 = taken) |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The bench builds the block with 8 history registers of 4 bits each, which gives a 16-entry counter table. With that small table, a few training steps are enough to make two branches share a counter, to drive a counter to both saturation limits, and to shift a history past its width so the oldest bit drops out. Two addresses that differ only outside the select field map to the same history register, which shows that the upper address bits are ignored. A 4-bit history covers the full period of a taken-taken-taken-not-taken loop exactly, so the loop test settles after a few iterations.

// File: rtl/lhp_pkg.sv
// Package: shared counter type and saturating-step helper for the
// per-branch history predictor. Assumes 2-bit counters whose upper bit
// is the taken/not-taken decision.
package lhp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    // One saturating step toward the resolved outcome.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t res;
        if (taken) begin
            res = (cur == CTR_STRONG_T) ? cur : ctr_t'(cur + 2'd1);
        end else begin
            res = (cur == CTR_STRONG_NT) ? cur : ctr_t'(cur - 2'd1);
        end
        return res;
    endfunction

endpackage

// File: rtl/lhp_history_table.sv
// History table: ENTRIES shift registers of HW bits, one per branch slot.
// One combinational read port for lookup and one for training, and one
// shift-in write port. Assumes the caller has already reduced each address
// to a slot number. The training read returns the pre-shift value.
module lhp_history_table #(
    parameter int ENTRIES = 128,
    parameter int HW      = 8,
    localparam int SEL_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] lk_sel,
    output logic [HW-1:0]    lk_hist,
    input  logic [SEL_W-1:0] tr_sel,
    output logic [HW-1:0]    tr_hist,
    input  logic             tr_en,
    input  logic             tr_bit
);

    logic [HW-1:0] hist_q [ENTRIES];

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            // Clear on reset; shift the outcome in when this slot is trained.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_q[g] <= '0;
                end else if (tr_en && (tr_sel == SEL_W'(g))) begin
                    hist_q[g] <= {hist_q[g][HW-2:0], tr_bit};
                end
            end
        end
    endgenerate

    // Read both ports straight from the registers.
    always_comb begin
        lk_hist = hist_q[lk_sel];
        tr_hist = hist_q[tr_sel];
    end

endmodule

// File: rtl/lhp_counter_table.sv
// Counter table: 2**HW saturating 2-bit counters indexed by a history value.
// The lookup read returns the upper bit. Training steps one counter toward
// the outcome. Assumes the training index is the history before its shift.
module lhp_counter_table
    import lhp_pkg::*;
#(
    parameter int HW      = 8,
    localparam int DEPTH  = 1 << HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] lk_idx,
    output logic          lk_taken,
    input  logic          tr_en,
    input  logic [HW-1:0] tr_idx,
    input  logic          tr_taken,
    output ctr_t          tr_cur,
    output ctr_t          tr_nxt
);

    ctr_t ctr_q [DEPTH];

    // Current and next value of the trained counter.
    always_comb begin
        tr_cur = ctr_q[tr_idx];
        tr_nxt = ctr_step(tr_cur, tr_taken);
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
            // Reset to weakly not taken; load the stepped value when trained.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctr_q[g] <= CTR_WEAK_NT;
                end else if (tr_en && (tr_idx == HW'(g))) begin
                    ctr_q[g] <= tr_nxt;
                end
            end
        end
    endgenerate

    // Prediction is the counter's upper bit.
    always_comb lk_taken = ctr_q[lk_idx][1];

endmodule

// File: rtl/local_hist_predictor.sv
// Top: two-level predictor with per-branch histories. Address bits
// [PC_LO +: SEL_W] pick a history; the history picks a counter. Lookup is
// combinational. A training event steps the counter at the old history,
// then shifts the outcome into the history, both on the same edge.
module local_hist_predictor
    import lhp_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int PC_LO        = 2,
    parameter int HIST_ENTRIES = 128,
    parameter int HIST_W       = 8,
    localparam int SEL_W       = $clog2(HIST_ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    logic [SEL_W-1:0]  lk_sel, tr_sel;
    logic [HIST_W-1:0] lk_hist, tr_hist;
    ctr_t              tr_cur, tr_nxt;

    // Reduce both addresses to a history slot number.
    always_comb begin
        lk_sel = pred_pc[PC_LO +: SEL_W];
        tr_sel = upd_pc[PC_LO +: SEL_W];
    end

    lhp_history_table #(
        .ENTRIES (HIST_ENTRIES),
        .HW      (HIST_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_sel  (lk_sel),
        .lk_hist (lk_hist),
        .tr_sel  (tr_sel),
        .tr_hist (tr_hist),
        .tr_en   (upd_valid),
        .tr_bit  (upd_taken)
    );

    lhp_counter_table #(
        .HW       (HIST_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_hist),
        .lk_taken (pred_taken),
        .tr_en    (upd_valid),
        .tr_idx   (tr_hist),
        .tr_taken (upd_taken),
        .tr_cur   (tr_cur),
        .tr_nxt   (tr_nxt)
    );

endmodule

// File: rtl/lhp_checker.sv
// Checker: temporal properties over the training path of the predictor.
// Bound into every instance of the top module.
module lhp_checker
    import lhp_pkg::*;
#(
    parameter int HIST_W = 8,
    parameter int SEL_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [SEL_W-1:0]  tr_sel,
    input logic [HIST_W-1:0] tr_hist,
    input ctr_t              tr_cur,
    input ctr_t              tr_nxt
);

    // R3
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && tr_cur == CTR_STRONG_T) |-> tr_nxt == CTR_STRONG_T);

    // R3
    sat_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && tr_cur == CTR_STRONG_NT) |-> tr_nxt == CTR_STRONG_NT);

    // R3
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && tr_cur != CTR_STRONG_T && tr_cur != CTR_STRONG_NT)
            |-> (upd_taken ? (tr_nxt == ctr_t'(tr_cur + 2'd1)) : (tr_nxt == ctr_t'(tr_cur - 2'd1))));

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ((tr_sel != $past(tr_sel))
            || (tr_hist == {$past(tr_hist[HIST_W-2:0]), $past(upd_taken)})));

    // R5
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ((tr_sel != $past(tr_sel)) || $stable(tr_hist)));

endmodule

bind local_hist_predictor lhp_checker #(
    .HIST_W (HIST_W),
    .SEL_W  (SEL_W)
) u_lhp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .tr_sel    (tr_sel),
    .tr_hist   (tr_hist),
    .tr_cur    (tr_cur),
    .tr_nxt    (tr_nxt)
);

// File: tb/local_hist_predictor_test.sv
// Bench: 8 histories of 4 bits, 16 counters. A vector walk, then directed
// checks for idle hold, reset and a period-4 loop.
module local_hist_predictor_test;

    localparam int PC_W = 32;
    localparam int NVEC = 18;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    local_hist_predictor #(
        .PC_W         (PC_W),
        .PC_LO        (2),
        .HIST_ENTRIES (8),
        .HIST_W       (4)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    // {pc, outcome, expected prediction before this training step}
    localparam logic [33:0] VEC [NVEC] = '{
        {32'h10, 1'b1, 1'b0},  // A h0000 c0 01->10
        {32'h10, 1'b1, 1'b0},  // A h0001 c1 01->10
        {32'h14, 1'b0, 1'b1},  // B h0000 shares c0 (R7) 10->01
        {32'h14, 1'b1, 1'b0},  // B h0000 c0 01->10
        {32'h14, 1'b1, 1'b1},  // B h0001 c1 10->11
        {32'h18, 1'b1, 1'b1},  // C h0000 c0 10->11
        {32'h18, 1'b0, 1'b1},  // C h0001 c1 11->10
        {32'h1C, 1'b1, 1'b1},  // D h0000 c0 stays 11
        {32'h1C, 1'b1, 1'b1},  // D h0001 c1 10->11
        {32'h20, 1'b0, 1'b1},  // E h0000 c0 11->10
        {32'h20, 1'b0, 1'b1},  // E h0000 c0 10->01
        {32'h20, 1'b0, 1'b0},  // E h0000 c0 01->00
        {32'h20, 1'b0, 1'b0},  // E h0000 c0 stays 00
        {32'h20, 1'b1, 1'b0},  // E h0000 c0 00->01
        {32'h30, 1'b1, 1'b0},  // same slot as A: h0011 c3 01->10
        {32'h10, 1'b1, 1'b0},  // A h0111 c7 01->10
        {32'h13, 1'b0, 1'b0},  // low bits ignored, A h1111 c15 01->00
        {32'h10, 1'b1, 1'b0}   // A h1110 (oldest bit dropped) c14 01->10
    };

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Present one training event, compare the same-cycle lookup, then clock it in.
    task automatic train(input logic [PC_W-1:0] pc, input logic t, input logic exp, input int idx);
        @(negedge clk);
        pred_pc   = pc;
        upd_pc    = pc;
        upd_taken = t;
        upd_valid = 1'b1;
        #1;
        check($sformatf("R2 R3 R4 R6 R7 step %0d", idx), pred_taken, exp);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int miss;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: fresh state predicts not taken everywhere
        pred_pc = 32'h10; #1; check("R1 reset pc 0x10", pred_taken, 1'b0);
        pred_pc = 32'hFFFF_FFFC; #1; check("R1 reset pc top", pred_taken, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            train(VEC[i][33:2], VEC[i][1], VEC[i][0], i);
        end

        // R5: D (history 0011, counter 10) unchanged while upd_valid is low
        @(negedge clk);
        pred_pc = 32'h1C; upd_pc = 32'h1C; upd_taken = 1'b0; upd_valid = 1'b0;
        #1; check("R5 before idle", pred_taken, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 after idle", pred_taken, 1'b1);

        // R1: mid-run reset returns D to weakly not taken
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1; check("R1 after second reset", pred_taken, 1'b0);

        // R8: TTTN loop, no misses in the second half
        miss = 0;
        for (int it = 0; it < 40; it++) begin
            for (int k = 0; k < 4; k++) begin
                logic outcome;
                outcome = (k != 3);
                @(negedge clk);
                pred_pc = 32'h40; upd_pc = 32'h40;
                upd_taken = outcome; upd_valid = 1'b1;
                #1;
                if (it >= 20 && pred_taken !== outcome) miss++;
                @(posedge clk);
            end
        end
        @(negedge clk);
        upd_valid = 1'b0;
        checks++;
        if (miss != 0) begin
            errors++;
            $display("FAIL R8 loop misses got %0d expected 0", miss);
        end

        finish_run();
    end

endmodule